// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the word address for a four-beat burst memory access. A start address is captured when either of two active-low address strobes calls for it. After that, the two least significant address bits step through a four-beat order while the upper bits stay as they were captured. The order is either linear (add the beat count) or interleaved (XOR the beat count). A static select input picks the order.

A controller-side strobe loads the address unconditionally. A processor-side strobe loads only while the active-low chip enable is asserted. An active-low advance input moves the burst one beat forward. When advance is inactive, the address holds. The outputs come straight from registers: the current internal address and the beat index.

There is no data stream at this block's edge. All pins are plain control or address signals with no valid/ready handshake and no back-pressure. A new address is taken on any clock edge where a load condition is true.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous active-high reset sets the internal address to zero and the beat index to zero on the next rising edge.
- R2: When the controller strobe is low at a rising edge, the full address input is captured and the beat index becomes 0, whatever the chip enable is.
- R3: When the processor strobe is low and the active-low chip enable is low at a rising edge, the address is captured and the beat index becomes 0.
- R4: A low processor strobe while chip enable is high (controller strobe high, advance high) has no effect: the address and beat index are unchanged.
- R5: Without a load, a low advance increments the 2-bit beat index by one per edge. A high advance leaves both the beat index and the address unchanged.
- R6: With the order select low (linear), the low two address bits equal the captured low bits plus the beat index, modulo 4. For example, a start of 2 gives 2,3,0,1.
- R7: With the order select high (interleaved), the low two address bits equal the captured low bits XOR the beat index. For example, a start of 1 gives 1,0,3,2.
- R8: A load in the same cycle as a low advance takes priority: the beat index becomes 0, not 1.
- R9: An advance after beat 3 wraps the beat index to 0, which returns the low bits to the start value.
- R10: Outside a load, the address bits above the two low bits never change; the low-bit stepping never carries into them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_in | input | ADDR_W | Start address presented for a load |
| strobe_ctrl_n | input | 1 | Controller address strobe, active low, not gated |
| strobe_proc_n | input | 1 | Processor address strobe, active low, gated by chip enable |
| chip_en_n | input | 1 | Chip enable, active low |
| advance_n | input | 1 | Burst advance, active low |
| order_interleave | input | 1 | Static order select: 1 interleaved, 0 linear |
| cur_addr | output | ADDR_W | Current internal burst address |
| beat_idx | output | 2 | Current beat number, 0 to 3 |

## Verification
Two functions can fall in the same cycle: a load and an advance. The bench drives a strobe together with a low advance and expects beat 0 at the captured start address, not the next beat. A second overlap pairs the processor strobe with an inactive chip enable. This case is judged by checking that the address and beat index stay unchanged across that edge. Every expected value comes from a reference model in the bench, pushed to a scoreboard queue and compared one nanosecond after each rising edge.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  localparam int unsigned BURST_BEATS = 4;
  localparam int unsigned BEAT_W      = $clog2(BURST_BEATS);

  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } order_e;

  typedef logic [BEAT_W-1:0] beat_t;
endpackage

// File: rtl/bseq_load_ctrl.sv
module bseq_load_ctrl (
  input  logic strobe_ctrl_n,
  input  logic strobe_proc_n,
  input  logic chip_en_n,
  output logic load_en
);
  logic ctrl_req;
  logic proc_req;

  always_comb begin
    ctrl_req = ~strobe_ctrl_n;
    proc_req = ~strobe_proc_n & ~chip_en_n;
    load_en  = ctrl_req | proc_req;
  end
endmodule

// File: rtl/bseq_beat_counter.sv
module bseq_beat_counter
  import bseq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  load_en,
  input  logic  advance_n,
  output beat_t beat
);
  beat_t beat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_q <= '0;
    end else if (load_en) begin
      beat_q <= '0;
    end else if (!advance_n) begin
      beat_q <= beat_q + beat_t'(1);
    end
  end

  assign beat = beat_q;
endmodule

// File: rtl/bseq_order_map.sv
module bseq_order_map
  import bseq_pkg::*;
(
  input  beat_t  start_low,
  input  beat_t  beat,
  input  order_e order,
  output beat_t  low_out
);
  beat_t lane [2];

  for (genvar g = 0; g < 2; g++) begin : g_lane
    if (g == int'(ORDER_LINEAR)) begin : g_lin
      assign lane[g] = start_low + beat;
    end else begin : g_ilv
      assign lane[g] = start_low ^ beat;
    end
  end

  assign low_out = lane[order];
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bseq_pkg::*;
#(
  parameter int unsigned ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              strobe_ctrl_n,
  input  logic              strobe_proc_n,
  input  logic              chip_en_n,
  input  logic              advance_n,
  input  logic              order_interleave,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [1:0]        beat_idx
);
  localparam int unsigned HI_W = ADDR_W - BEAT_W;

  logic              load_en;
  logic [ADDR_W-1:0] base_q;
  beat_t             beat;
  beat_t             low_bits;
  order_e            order;

  assign order = order_e'(order_interleave);

  bseq_load_ctrl u_load (
    .strobe_ctrl_n (strobe_ctrl_n),
    .strobe_proc_n (strobe_proc_n),
    .chip_en_n     (chip_en_n),
    .load_en       (load_en)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
    end else if (load_en) begin
      base_q <= addr_in;
    end
  end

  bseq_beat_counter u_cnt (
    .clk       (clk),
    .rst       (rst),
    .load_en   (load_en),
    .advance_n (advance_n),
    .beat      (beat)
  );

  bseq_order_map u_map (
    .start_low (base_q[BEAT_W-1:0]),
    .beat      (beat),
    .order     (order),
    .low_out   (low_bits)
  );

  assign cur_addr = {base_q[ADDR_W-1 -: HI_W], low_bits};
  assign beat_idx = beat;
endmodule

// File: rtl/bseq_checker.sv
module bseq_checker #(
  parameter int unsigned ADDR_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr_in,
  input logic              strobe_ctrl_n,
  input logic              strobe_proc_n,
  input logic              chip_en_n,
  input logic              advance_n,
  input logic              order_interleave,
  input logic [ADDR_W-1:0] cur_addr,
  input logic [1:0]        beat_idx
);
  logic loading;
  assign loading = !strobe_ctrl_n || (!strobe_proc_n && !chip_en_n);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (cur_addr == '0 && beat_idx == 2'd0));

  assert_ctrl_load_R2: assert property (@(posedge clk) disable iff (rst)
    !strobe_ctrl_n |=> (cur_addr == $past(addr_in) && beat_idx == 2'd0));

  assert_proc_load_R3: assert property (@(posedge clk) disable iff (rst)
    (!strobe_proc_n && !chip_en_n) |=> (cur_addr == $past(addr_in) && beat_idx == 2'd0));

  assert_gated_ignore_R4: assert property (@(posedge clk) disable iff (rst)
    (strobe_ctrl_n && !strobe_proc_n && chip_en_n && advance_n)
      |=> ($stable(cur_addr) && $stable(beat_idx)));

  assert_step_R5: assert property (@(posedge clk) disable iff (rst)
    (!loading && !advance_n) |=> (beat_idx == 2'($past(beat_idx) + 2'd1)));

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!loading && advance_n) |=> ($stable(beat_idx) && $stable(cur_addr)));

  assert_linear_R6: assert property (@(posedge clk) disable iff (rst)
    (!loading && !advance_n && !order_interleave)
      |=> (cur_addr[1:0] == 2'($past(cur_addr[1:0]) + 2'd1)));

  assert_interleave_R7: assert property (@(posedge clk) disable iff (rst)
    (!loading && !advance_n && order_interleave)
      |=> ((cur_addr[1:0] ^ $past(cur_addr[1:0])) == (beat_idx ^ $past(beat_idx))));

  assert_upper_fixed_R10: assert property (@(posedge clk) disable iff (rst)
    !loading |=> (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2])));
endmodule

bind burst_addr_seq bseq_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk              (clk),
  .rst              (rst),
  .addr_in          (addr_in),
  .strobe_ctrl_n    (strobe_ctrl_n),
  .strobe_proc_n    (strobe_proc_n),
  .chip_en_n        (chip_en_n),
  .advance_n        (advance_n),
  .order_interleave (order_interleave),
  .cur_addr         (cur_addr),
  .beat_idx         (beat_idx)
);

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;
  localparam int AW = 18;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic          strobe_ctrl_n = 1'b1;
  logic          strobe_proc_n = 1'b1;
  logic          chip_en_n = 1'b1;
  logic          advance_n = 1'b1;
  logic          order_interleave = 1'b0;
  logic [AW-1:0] cur_addr;
  logic [1:0]    beat_idx;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [AW-1:0] exp_a[$];
  logic [1:0]    exp_b[$];
  string         exp_tag[$];

  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_cnt = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .addr_in(addr_in),
    .strobe_ctrl_n(strobe_ctrl_n), .strobe_proc_n(strobe_proc_n),
    .chip_en_n(chip_en_n), .advance_n(advance_n),
    .order_interleave(order_interleave),
    .cur_addr(cur_addr), .beat_idx(beat_idx)
  );

  function automatic logic [AW-1:0] model_addr();
    logic [1:0] lo;
    lo = order_interleave ? (m_base[1:0] ^ m_cnt) : 2'(m_base[1:0] + m_cnt);
    return {m_base[AW-1:2], lo};
  endfunction

  task automatic step(input logic c_n, input logic p_n, input logic ce_n,
                      input logic adv_n, input logic [AW-1:0] a, input string tag);
    @(negedge clk);
    strobe_ctrl_n = c_n; strobe_proc_n = p_n; chip_en_n = ce_n;
    advance_n = adv_n; addr_in = a;
    if (!c_n || (!p_n && !ce_n)) begin
      m_base = a; m_cnt = 2'd0;
    end else if (!adv_n) begin
      m_cnt = m_cnt + 2'd1;
    end
    exp_a.push_back(model_addr());
    exp_b.push_back(m_cnt);
    exp_tag.push_back(tag);
  endtask

  always @(posedge clk) begin
    #1ns;
    if (exp_a.size() > 0) begin
      logic [AW-1:0] ea;
      logic [1:0] eb;
      string t;
      ea = exp_a.pop_front(); eb = exp_b.pop_front(); t = exp_tag.pop_front();
      checks++;
      if (cur_addr !== ea || beat_idx !== eb) begin
        failures++;
        $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
                 t, cur_addr, beat_idx, ea, eb);
      end
    end
  end

  task automatic check_reset(input string tag);
    @(negedge clk);
    checks++;
    if (cur_addr !== '0 || beat_idx !== 2'd0) begin
      failures++;
      $display("FAIL %s: addr=%h beat=%0d expected addr=0 beat=0", tag, cur_addr, beat_idx);
    end
  endtask

  task automatic do_reset(input logic ilv);
    @(negedge clk);
    rst = 1'b1; order_interleave = ilv;
    strobe_ctrl_n = 1'b1; strobe_proc_n = 1'b1; chip_en_n = 1'b1; advance_n = 1'b1;
    @(posedge clk);
    check_reset("R1");
    rst = 1'b0;
    m_base = '0; m_cnt = 2'd0;
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end

  initial begin
    do_reset(1'b0);
    // R2: controller strobe loads with chip enable inactive; linear R6 2,3,0,1
    step(0, 1, 1, 1, 18'h1234A, "R2");
    step(1, 1, 1, 0, '0, "R6 beat1");
    step(1, 1, 1, 0, '0, "R6 beat2");
    step(1, 1, 1, 0, '0, "R6 beat3");
    step(1, 1, 1, 0, '0, "R9 wrap");
    // R5 hold
    step(1, 1, 1, 1, '0, "R5 hold");
    step(1, 1, 1, 1, 18'h3FFFF, "R5 hold2");
    step(1, 1, 1, 0, '0, "R5 step");
    // R3 + R8: processor load with advance in same cycle
    step(1, 0, 0, 0, 18'h00F01, "R8 load over advance");
    step(1, 1, 1, 0, '0, "R3 then step");
    // R4: gated processor strobe ignored
    step(1, 0, 1, 1, 18'h2AAAA, "R4 ignored");
    step(1, 0, 1, 1, 18'h15555, "R4 ignored2");
    // R10: upper bits untouched when low bits roll 3->0
    step(0, 1, 0, 1, 18'h3FFFF, "R10 load");
    step(1, 1, 1, 0, '0, "R10 roll");
    step(1, 1, 1, 0, '0, "R10 roll2");
    // reset from non-zero state, switch to interleaved
    step(1, 1, 1, 0, '0, "R10 roll3");
    @(posedge clk); #2ns;
    do_reset(1'b1);
    // R7: start 1 gives 1,0,3,2
    step(0, 1, 1, 1, 18'h20001, "R7 load");
    step(1, 1, 1, 0, '0, "R7 beat1");
    step(1, 1, 1, 0, '0, "R7 beat2");
    step(1, 1, 1, 0, '0, "R7 beat3");
    step(1, 1, 1, 0, '0, "R9 ilv wrap");
    // R7 start 2: 2,3,0,1 ; R2 load with advance low -> R8
    step(0, 1, 0, 0, 18'h0BEE2, "R8 ctrl load over advance");
    step(1, 1, 1, 0, '0, "R7 s2 beat1");
    step(1, 1, 1, 0, '0, "R7 s2 beat2");
    step(1, 1, 1, 0, '0, "R7 s2 beat3");
    step(1, 0, 1, 0, 18'h11111, "R4 gated with advance");
    step(1, 1, 1, 1, '0, "R5 ilv hold");
    repeat (3) @(posedge clk);
    #2ns;
    done = 1'b1;
    finish_run();
  end
endmodule